// File: doc/BRIEF.md
# Multiplier-Free Decision Feedback Equalizer

This block equalizes a stream of received samples. It has two filters and neither one uses a hardware multiplier. The feed-forward filter works on the incoming samples. The feedback filter works on the equalizer's own earlier decisions. Each filter is a digit-serial distributed-arithmetic engine. A shared table lookup forms the sum of the coefficients that are selected by one bit-plane of the tap registers. The engine handles P bit-planes per cycle and adds them into a shift-accumulator, most significant digit first. Both engines use the same digit width, so both finish a symbol after Q = B/P cycles and their results are ready together.

The feedback result is subtracted from the feed-forward result. The slicer then makes an antipodal decision from the sign of that difference. The decision is registered and sent out on a valid/ready stream. The decision is also shifted into the feedback tap line when the next sample is accepted. Samples arrive on a valid/ready stream. A sender must hold `in_valid` and `in_data` until the handshake. The block takes one sample at most every Q cycles. If the output is blocked, the block keeps the pending decision, stalls its last digit step and deasserts `in_ready`. The coefficients are parameters, and the lookup tables are built from them at elaboration. B must be a multiple of P.

Top module: `dfe_equalizer`

## Requirements
- R1: During and right after reset, `out_valid` is 0, `in_ready` is 1, `out_data` is 0, and every feed-forward and feedback tap holds zero.
- R2: For the accepted sample n, the error is r(n) = Σ w_i·u(n−i) − Σ v_i·s(n−i). Tap 0 of each filter is its newest entry, and w_i occupies bits [i·CW +: CW] of the feed-forward coefficient vector.
- R3: The feedback tap line holds only past decisions: s(n) is the decision made for sample n−1, and s(0) is zero.
- R4: The decision is +0.5, coded 2^(B−2) (8'h40 for B=8), when r(n) ≥ 0. It is −0.5, coded 8'hC0 for B=8, when r(n) < 0.
- R5: Samples and coefficients are signed two's complement. The sample MSB carries negative weight, so every one of the 2^B input codes is handled.
- R6: After an accepted sample, `in_ready` is low for the next Q−1 cycles. When the output is not blocked and `in_valid` stays high, accepts occur exactly every Q cycles.
- R7: The decision for a sample is presented on `out_valid` Q cycles after the accepting clock edge, unless the output is blocked.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged, and no later decision overwrites them.
- R9: When a decision completes in the same cycle that the next sample is accepted, that new decision enters the feedback tap line at that edge.
- R10: When an output handshake and the completion of the next decision happen in the same cycle, `out_valid` stays high and carries the new decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample can be taken this cycle |
| in_data | input | B | Received sample, signed fraction |
| out_valid | output | 1 | Decision available |
| out_ready | input | 1 | Consumer takes the decision |
| out_data | output | B | Decision, ±0.5 code |

## Verification
Two events can land on the same clock edge. One is the completion of a decision. The other is the acceptance of the next sample, which must shift that same decision into the feedback line. With `in_valid` held high and `out_ready` high, every symbol makes these two events coincide. The bench sweeps all 256 sample codes in this mode and checks each decision against an integer model of the loop, along with the exact accept spacing and the output latency. A second pass throttles both streams with a pseudo-random pattern. That makes the output handshake and the next decision coincide, and also stalls the last digit step; the held decision is checked on every blocked cycle.

// File: rtl/dfe_pkg.sv
`timescale 1ns/1ps
package dfe_pkg;

  typedef enum logic {ST_IDLE, ST_RUN} dfe_state_e;

  function automatic int cnt_width(int q);
    return (q > 1) ? $clog2(q) : 1;
  endfunction

  // signed width of a sum of n coefficients of cw bits
  function automatic int lut_width(int n, int cw);
    return cw + $clog2(n + 1);
  endfunction

  // accumulator width holding a full dot product with b-bit samples
  function automatic int acc_width(int n, int cw, int b);
    return lut_width(n, cw) + b + 1;
  endfunction

endpackage

// File: rtl/dfe_tap_line.sv
`timescale 1ns/1ps
module dfe_tap_line #(
  parameter int N = 4,
  parameter int B = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic [B-1:0] din,
  output logic [N*B-1:0] taps
);

  generate
    if (N > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n)     taps <= '0;
        else if (shift) taps <= {taps[(N-1)*B-1:0], din};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n)     taps <= '0;
        else if (shift) taps <= din;
      end
    end
  endgenerate

endmodule

// File: rtl/dfe_da_rom.sv
`timescale 1ns/1ps
module dfe_da_rom #(
  parameter int N     = 4,
  parameter int CW    = 8,
  parameter logic [N*CW-1:0] COEF = '0,
  parameter int PORTS = 2,
  parameter int LW    = 11
) (
  input  logic [PORTS*N-1:0]  addr,
  output logic [PORTS*LW-1:0] data
);

  localparam int DEPTH = 1 << N;

  function automatic logic signed [LW-1:0] entry(int a);
    logic signed [LW-1:0] s;
    s = '0;
    for (int i = 0; i < N; i++)
      if (a[i]) s = s + LW'($signed(COEF[i*CW +: CW]));
    return s;
  endfunction

  logic signed [LW-1:0] table_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign table_q[g] = entry(g);
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    assign data[p*LW +: LW] = table_q[addr[p*N +: N]];
  end

endmodule

// File: rtl/dfe_da_engine.sv
`timescale 1ns/1ps
module dfe_da_engine import dfe_pkg::*; #(
  parameter int N  = 4,
  parameter int B  = 8,
  parameter int P  = 2,
  parameter int CW = 8,
  parameter logic [N*CW-1:0] COEF = '0,
  localparam int Q    = B / P,
  localparam int CNTW = cnt_width(Q),
  localparam int LW   = lut_width(N, CW),
  localparam int AW   = acc_width(N, CW, B),
  localparam int CTW  = LW + P + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 step,
  input  logic [CNTW-1:0]      cnt,
  input  logic [N*B-1:0]       taps,
  output logic signed [AW-1:0] acc_next
);

  logic [P*N-1:0]        addr;
  logic [P*LW-1:0]       data;
  logic signed [CTW-1:0] contrib;
  logic signed [AW-1:0]  acc_q;

  // digit taken this step: most significant first
  always_comb begin
    addr = '0;
    for (int p = 0; p < P; p++) begin
      for (int i = 0; i < N; i++) begin
        int pos;
        pos = (Q - 1 - int'(cnt)) * P + p;
        addr[p*N + i] = taps[i*B + pos];
      end
    end
  end

  dfe_da_rom #(
    .N(N), .CW(CW), .COEF(COEF), .PORTS(P), .LW(LW)
  ) rom_i (
    .addr(addr),
    .data(data)
  );

  always_comb begin
    contrib = '0;
    for (int p = 0; p < P; p++) begin
      logic signed [CTW-1:0] term;
      term = CTW'($signed(data[p*LW +: LW])) <<< p;
      // sample MSB plane carries negative weight
      if ((cnt == '0) && (p == P - 1)) contrib = contrib - term;
      else                             contrib = contrib + term;
    end
    acc_next = (acc_q <<< P) + AW'(contrib);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     acc_q <= '0;
    else if (clear) acc_q <= '0;
    else if (step)  acc_q <= acc_next;
  end

endmodule

// File: rtl/dfe_equalizer.sv
`timescale 1ns/1ps
module dfe_equalizer import dfe_pkg::*; #(
  parameter int B  = 8,
  parameter int P  = 2,
  parameter int NF = 4,
  parameter int NB = 2,
  parameter int CW = 8,
  parameter logic [NF*CW-1:0] FF_COEF = 32'hF614E264,
  parameter logic [NB*CW-1:0] FB_COEF = 16'hE728
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [B-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [B-1:0] out_data
);

  localparam int Q    = B / P;
  localparam int CNTW = cnt_width(Q);
  localparam int AF   = acc_width(NF, CW, B);
  localparam int AB   = acc_width(NB, CW, B);
  localparam int RW   = ((AF > AB) ? AF : AB) + 1;
  localparam logic [B-1:0] DEC_POS = B'(1) << (B - 2);
  localparam logic [B-1:0] DEC_NEG = ~DEC_POS + B'(1);

  dfe_state_e      state_q;
  logic [CNTW-1:0] cnt_q;
  logic [B-1:0]    dec_q;
  logic            valid_q;

  logic last, out_block, fin, step, accept;
  logic [B-1:0] dec_new, fb_din;
  logic [NF*B-1:0] ff_taps;
  logic [NB*B-1:0] fb_taps;
  logic signed [AF-1:0] ff_sum;
  logic signed [AB-1:0] fb_sum;
  logic signed [RW-1:0] err;

  assign last      = (state_q == ST_RUN) && (cnt_q == CNTW'(Q - 1));
  assign out_block = valid_q && !out_ready;
  assign fin       = last && !out_block;
  assign step      = (state_q == ST_RUN) && !(last && out_block);
  assign in_ready  = (state_q == ST_IDLE) || fin;
  assign accept    = in_valid && in_ready;

  // slicer on the error sample
  assign err     = RW'(ff_sum) - RW'(fb_sum);
  assign dec_new = err[RW-1] ? DEC_NEG : DEC_POS;

  // newest decision forwarded when it completes on the accepting edge
  assign fb_din = fin ? dec_new : dec_q;

  dfe_tap_line #(.N(NF), .B(B)) ff_line_i (
    .clk(clk), .rst_n(rst_n), .shift(accept), .din(in_data), .taps(ff_taps)
  );

  dfe_tap_line #(.N(NB), .B(B)) fb_line_i (
    .clk(clk), .rst_n(rst_n), .shift(accept), .din(fb_din), .taps(fb_taps)
  );

  dfe_da_engine #(
    .N(NF), .B(B), .P(P), .CW(CW), .COEF(FF_COEF)
  ) ff_eng_i (
    .clk(clk), .rst_n(rst_n), .clear(accept), .step(step),
    .cnt(cnt_q), .taps(ff_taps), .acc_next(ff_sum)
  );

  dfe_da_engine #(
    .N(NB), .B(B), .P(P), .CW(CW), .COEF(FB_COEF)
  ) fb_eng_i (
    .clk(clk), .rst_n(rst_n), .clear(accept), .step(step),
    .cnt(cnt_q), .taps(fb_taps), .acc_next(fb_sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (accept) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else if (fin) begin
      state_q <= ST_IDLE;
    end else if (step) begin
      cnt_q <= cnt_q + CNTW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_q   <= '0;
      valid_q <= 1'b0;
    end else if (fin) begin
      dec_q   <= dec_new;
      valid_q <= 1'b1;
    end else if (valid_q && out_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = dec_q;

endmodule

// File: rtl/dfe_equalizer_chk.sv
`timescale 1ns/1ps
module dfe_equalizer_chk #(
  parameter int B = 8,
  parameter int P = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [B-1:0] out_data
);

  localparam int Q = B / P;
  localparam logic [B-1:0] POS = B'(1) << (B - 2);
  localparam logic [B-1:0] NEG = ~POS + B'(1);

  // edges since the most recent accept, saturating
  int unsigned gap_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                        gap_q <= 0;
    else if (in_valid && in_ready)     gap_q <= 0;
    else if (gap_q < Q + 2)            gap_q <= gap_q + 1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> !out_valid && out_data == '0);

  assert_decision_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data == POS || out_data == NEG));

  assert_accept_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && Q > 1) |=> !in_ready);

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(gap_q) == Q - 1);

  assert_hold_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data));

endmodule

bind dfe_equalizer dfe_equalizer_chk #(.B(B), .P(P)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/dfe_equalizer_tb_top.sv
`timescale 1ns/1ps
module dfe_equalizer_tb_top;

  localparam int B  = 8;
  localparam int P  = 2;
  localparam int Q  = B / P;
  localparam int NF = 4;
  localparam int NB = 2;
  localparam int NA = 256;          // full code sweep, streaming
  localparam int TOTAL = NA + 300;  // plus throttled pass
  localparam int LIMIT = 100000;

  logic clk = 1'b0;
  logic rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [B-1:0] in_data, out_data;

  always #2 clk = ~clk;

  dfe_equalizer #(
    .B(B), .P(P), .NF(NF), .NB(NB), .CW(8),
    .FF_COEF(32'hF614E264), .FB_COEF(16'hE728)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  int wf [NF] = '{100, -30, 20, -10};
  int wb [NB] = '{40, -25};
  int uh [NF];
  int dh [NB];
  logic [B-1:0] exp_q [TOTAL];
  int acc_cyc [TOTAL];
  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // integer model of the loop: R2, R3, R4, R5
  task automatic model_push(input logic [B-1:0] x, input int idx);
    int yf, yb, d;
    for (int i = NF - 1; i > 0; i--) uh[i] = uh[i-1];
    uh[0] = int'($signed(x));
    yf = 0; yb = 0;
    for (int i = 0; i < NF; i++) yf += wf[i] * uh[i];
    for (int i = 0; i < NB; i++) yb += wb[i] * dh[i];
    d = ((yf - yb) >= 0) ? 64 : -64;
    exp_q[idx] = B'(d);
    for (int i = NB - 1; i > 0; i--) dh[i] = dh[i-1];
    dh[0] = d;
  endtask

  initial begin
    int sent, got, cyc, last_acc;
    bit prev_block, pending;
    logic [B-1:0] prev_data, cur;
    logic [15:0] lfsr;
    sent = 0; got = 0; cyc = 0; last_acc = 0;
    prev_block = 0; pending = 0; prev_data = '0; lfsr = 16'hACE1;
    for (int i = 0; i < NF; i++) uh[i] = 0;
    for (int i = 0; i < NB; i++) dh[i] = 0;

    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_data == '0, "R1 out_data after reset", int'(out_data), 0);
    @(posedge clk); #1;

    cur = '0;
    while (got < TOTAL && cyc < LIMIT) begin
      // drive inputs
      if (sent < NA) begin
        in_valid = 1'b1;
        in_data  = B'(sent);
      end else if (sent < TOTAL) begin
        if (!pending) begin
          pending = lfsr[0] | lfsr[5];
          cur = lfsr[15:8];
        end
        in_valid = pending;
        in_data  = cur;
      end else begin
        in_valid = 1'b0;
      end
      out_ready = (got < NA) ? 1'b1 : (lfsr[3] | lfsr[9]);

      @(negedge clk);
      cyc++;
      if (prev_block) begin
        chk(out_valid == 1'b1, "R8 valid held", int'(out_valid), 1);
        chk(out_data == prev_data, "R8 data held", int'(out_data), int'(prev_data));
      end
      if (out_valid && out_ready) begin
        chk(out_data == exp_q[got], "R2 R3 R4 R5 decision", int'(out_data), int'(exp_q[got]));
        if (got < NA)
          chk(cyc - acc_cyc[got] == Q + 1, "R7 latency", cyc - acc_cyc[got], Q + 1);
        got++;
      end
      if (in_valid && in_ready) begin
        model_push(in_data, sent);
        acc_cyc[sent] = cyc;
        // back-to-back accepts coincide with decision write-back (R9, R10)
        if (sent > 0 && sent < NA)
          chk(cyc - last_acc == Q, "R6 R9 accept spacing", cyc - last_acc, Q);
        last_acc = cyc;
        sent++;
        pending = 0;
      end
      prev_block = out_valid && !out_ready;
      prev_data  = out_data;
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    if (got < TOTAL) begin
      checks++; fails++;
      $display("FAIL watchdog R6 R7 decisions=%0d expected=%0d", got, TOTAL);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule